// File: doc/BRIEF.md
# Cache Tag Store with Hit Comparator

This block keeps one tag per cache line in an 8192-entry by 8-bit store and answers, on every clock, whether the tag held at the presented index equals the tag presented on the data input. A cache controller drives the line index and the upper address bits, and reads the `match` flag one clock later to decide hit or miss. The same index and data lines also load new tags and read stored tags back.

All control inputs are active low: select, write strobe, output strobe and clear. The hit flag is only meaningful in compare mode. In every other state (deselected, writing, reading onto the bus, or being cleared) it is held high, so a deselected store never signals a miss. The read path models a tri-state bus with a drive-enable flag and returns zero on the data lines when not driving.

Pulling the clear input low starts a sweep that writes zero into every entry, one per clock, with `busy` high until the sweep ends. Writes presented during the sweep are dropped.

Top module: `tag_match_ram`

## Requirements
- R1: The store has 2^13 = 8192 entries of 8 bits, indexed by `idx`. A tag written at an index is the value later read or compared at that index.
- R2: A tag is written only on a rising edge where `sel_n` and `wen_n` are both 0, `clear_n` is 1 and `busy` is 0.
- R3: In compare mode (`clear_n`=1, `sel_n`=0, `wen_n`=1, `oen_n`=1) sampled at a rising edge, `match` after that edge is 1 if the stored tag at `idx` equals `din`, else 0.
- R4: `sel_n`=1 at a rising edge forces `match`=1 after that edge.
- R5: `wen_n`=0 at a rising edge forces `match`=1 and `dout_en`=0 after that edge, whatever the order in which `sel_n` and `wen_n` went low.
- R6: `oen_n`=0 at a rising edge forces `match`=1 after that edge.
- R7: `clear_n`=0 at a rising edge forces `match`=1, `busy`=1 and `dout_en`=0 after that edge.
- R8: In read mode (`clear_n`=1, `sel_n`=0, `oen_n`=0, `wen_n`=1) at a rising edge, after that edge `dout_en`=1 and `dout` holds the stored tag at `idx`.
- R9: `dout_en` is 1 only after a read-mode edge, and `dout` is 0 while `dout_en` is 0.
- R10: After `clear_n` returns to 1, `busy` stays 1 for exactly 8192 rising edges and then falls. Every entry then reads 0.
- R11: Write requests presented while `busy` is 1 leave the store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clear_n | input | 1 | Active-low clear; starts the zeroing sweep and forces `match` high |
| sel_n | input | 1 | Active-low select |
| wen_n | input | 1 | Active-low write strobe |
| oen_n | input | 1 | Active-low output strobe (read onto the bus) |
| idx | input | 13 | Line index |
| din | input | 8 | Tag to store or to compare |
| match | output | 1 | Hit flag; high on equality or when forced |
| dout | output | 8 | Read data; zero when not driving |
| dout_en | output | 1 | Bus drive enable for `dout` |
| busy | output | 1 | High while the clear sweep runs |

## Verification
A corrupted entry shows up as a wrong `match` on the first compare of that index and as a wrong `dout` on the first read, one clock after the access is sampled. A wrong mode register shows up at once as a low `match` outside compare mode or a stray `dout_en`. A sweep pointer that skips or stops early shows as a `busy` pulse of the wrong length, or as a nonzero tag read from the highest or lowest index after the sweep. A write that leaks through during the sweep or while deselected shows on the next read of that index.

// File: rtl/tagram_pkg.sv
package tagram_pkg;

  // Operating state of one access, decoded from the active-low controls.
  // Priority: clear, then deselect, then write, then read, then compare.
  typedef enum logic [2:0] {
    MODE_IDLE  = 3'd0,
    MODE_WRITE = 3'd1,
    MODE_READ  = 3'd2,
    MODE_CMP   = 3'd3,
    MODE_CLEAR = 3'd4
  } mode_e;

endpackage

// File: rtl/tagram_decode.sv
module tagram_decode
  import tagram_pkg::*;
(
  input  logic  clear_n,
  input  logic  sel_n,
  input  logic  wen_n,
  input  logic  oen_n,
  input  logic  busy,
  output mode_e mode,
  output logic  usr_we
);

  always_comb begin
    if (!clear_n)      mode = MODE_CLEAR;
    else if (sel_n)    mode = MODE_IDLE;
    else if (!wen_n)   mode = MODE_WRITE;
    else if (!oen_n)   mode = MODE_READ;
    else               mode = MODE_CMP;
  end

  // A user write is dropped while the sweep owns the write port.
  assign usr_we = (mode == MODE_WRITE) && !busy;

endmodule

// File: rtl/tagram_clear.sv
module tagram_clear #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              clear_n,
  output logic              busy,
  output logic [ADDR_W-1:0] ptr,
  output logic              clr_we
);

  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  // Holding clear_n low parks the pointer at zero; the sweep runs after release.
  always_ff @(posedge clk) begin
    if (!clear_n) begin
      busy <= 1'b1;
      ptr  <= '0;
    end else if (busy) begin
      ptr <= ptr + 1'b1;
      if (ptr == LAST) busy <= 1'b0;
    end
  end

  assign clr_we = busy && clear_n;

endmodule

// File: rtl/tagram_store.sv
module tagram_store #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // One write port, one registered read port: maps onto a simple dual-port RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/tag_match_ram.sv
module tag_match_ram
  import tagram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              clear_n,
  input  logic              sel_n,
  input  logic              wen_n,
  input  logic              oen_n,
  input  logic [ADDR_W-1:0] idx,
  input  logic [DATA_W-1:0] din,
  output logic              match,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy
);

  mode_e             mode;
  mode_e             mode_q;
  logic              usr_we;
  logic              clr_we;
  logic [ADDR_W-1:0] ptr;
  logic              st_we;
  logic [ADDR_W-1:0] st_waddr;
  logic [DATA_W-1:0] st_wdata;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] din_q;
  logic              dout_en_q;

  tagram_decode u_decode (
    .clear_n (clear_n),
    .sel_n   (sel_n),
    .wen_n   (wen_n),
    .oen_n   (oen_n),
    .busy    (busy),
    .mode    (mode),
    .usr_we  (usr_we)
  );

  tagram_clear #(.ADDR_W(ADDR_W)) u_clear (
    .clk     (clk),
    .clear_n (clear_n),
    .busy    (busy),
    .ptr     (ptr),
    .clr_we  (clr_we)
  );

  // The sweep has the write port whenever it runs.
  assign st_we    = clr_we || usr_we;
  assign st_waddr = clr_we ? ptr : idx;
  assign st_wdata = clr_we ? '0  : din;

  tagram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .we    (st_we),
    .waddr (st_waddr),
    .wdata (st_wdata),
    .raddr (idx),
    .rdata (rd_q)
  );

  always_ff @(posedge clk) begin
    mode_q    <= mode;
    din_q     <= din;
    dout_en_q <= (mode == MODE_READ);
  end

  // Comparator sits after the RAM output register and the sampled tag.
  assign match   = (mode_q == MODE_CMP) ? (rd_q == din_q) : 1'b1;
  assign dout_en = dout_en_q;
  assign dout    = dout_en_q ? rd_q : '0;

endmodule

// File: rtl/tag_match_ram_chk.sv
module tag_match_ram_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              clear_n,
  input logic              sel_n,
  input logic              wen_n,
  input logic              oen_n,
  input logic [ADDR_W-1:0] idx,
  input logic [DATA_W-1:0] din,
  input logic              match,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              busy
);

  // Checks start once a clear has been sampled; before that no state is defined.
  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clear_n) armed <= 1'b1;

  // R4
  desel_forces_match_chk: assert property (@(posedge clk) disable iff (!armed)
    sel_n |=> match);

  // R5
  write_forces_match_chk: assert property (@(posedge clk) disable iff (!armed)
    !wen_n |=> (match && !dout_en));

  // R6
  oe_forces_match_chk: assert property (@(posedge clk) disable iff (!armed)
    !oen_n |=> match);

  // R7
  clear_forces_state_chk: assert property (@(posedge clk) disable iff (!armed)
    !clear_n |=> (match && busy && !dout_en));

  // R8
  read_drives_bus_chk: assert property (@(posedge clk) disable iff (!armed)
    (clear_n && !sel_n && !oen_n && wen_n) |=> dout_en);

  // R9
  drive_only_after_read_chk: assert property (@(posedge clk) disable iff (!armed)
    !(clear_n && !sel_n && !oen_n && wen_n) |=> !dout_en);

  // R9
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    !dout_en |-> (dout == '0));

  // R10
  busy_falls_released_chk: assert property (@(posedge clk) disable iff (!armed)
    $fell(busy) |-> $past(clear_n));

endmodule

bind tag_match_ram tag_match_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .clear_n (clear_n),
  .sel_n   (sel_n),
  .wen_n   (wen_n),
  .oen_n   (oen_n),
  .idx     (idx),
  .din     (din),
  .match   (match),
  .dout    (dout),
  .dout_en (dout_en),
  .busy    (busy)
);

// File: tb/test_tag_match_ram.sv
module test_tag_match_ram;

  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 8192;

  logic              clk = 1'b0;
  logic              clear_n = 1'b0;
  logic              sel_n = 1'b1;
  logic              wen_n = 1'b1;
  logic              oen_n = 1'b1;
  logic [ADDR_W-1:0] idx = '0;
  logic [DATA_W-1:0] din = '0;
  logic              match;
  logic [DATA_W-1:0] dout;
  logic              dout_en;
  logic              busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tag_match_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_tag_match_ram (
    .clk (clk), .clear_n (clear_n), .sel_n (sel_n), .wen_n (wen_n),
    .oen_n (oen_n), .idx (idx), .din (din), .match (match),
    .dout (dout), .dout_en (dout_en), .busy (busy)
  );

  typedef struct packed {
    logic              s, w, o;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    logic [3:0]        rq;
    logic              em, een;
    logic [DATA_W-1:0] ed;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b1,13'h0005,8'hA5,4'd5, 1'b1,1'b0,8'h00}, // R5 write
    '{1'b0,1'b0,1'b1,13'h1FFF,8'h3C,4'd5, 1'b1,1'b0,8'h00}, // R5 write top index
    '{1'b0,1'b0,1'b1,13'h0000,8'hFF,4'd5, 1'b1,1'b0,8'h00}, // R5 write index 0
    '{1'b0,1'b1,1'b1,13'h0005,8'hA5,4'd3, 1'b1,1'b0,8'h00}, // R3 hit
    '{1'b0,1'b1,1'b1,13'h0005,8'hA4,4'd3, 1'b0,1'b0,8'h00}, // R3 miss by one bit
    '{1'b0,1'b1,1'b1,13'h1FFF,8'h3C,4'd1, 1'b1,1'b0,8'h00}, // R1 top index hit
    '{1'b0,1'b1,1'b1,13'h0000,8'hFF,4'd1, 1'b1,1'b0,8'h00}, // R1 index 0 hit
    '{1'b0,1'b1,1'b1,13'h0007,8'h00,4'd10,1'b1,1'b0,8'h00}, // R10 cleared entry
    '{1'b0,1'b1,1'b1,13'h0007,8'h01,4'd3, 1'b0,1'b0,8'h00}, // R3 miss
    '{1'b0,1'b1,1'b0,13'h0005,8'h00,4'd8, 1'b1,1'b1,8'hA5}, // R8 read
    '{1'b0,1'b1,1'b0,13'h1FFF,8'h00,4'd8, 1'b1,1'b1,8'h3C}, // R8 read top
    '{1'b1,1'b0,1'b1,13'h0005,8'h11,4'd4, 1'b1,1'b0,8'h00}, // R4 deselected write
    '{1'b0,1'b0,1'b1,13'h0008,8'h22,4'd5, 1'b1,1'b0,8'h00}, // R5 select after strobe
    '{1'b0,1'b1,1'b1,13'h0005,8'hA5,4'd2, 1'b1,1'b0,8'h00}, // R2 not overwritten
    '{1'b1,1'b1,1'b1,13'h0005,8'h00,4'd4, 1'b1,1'b0,8'h00}, // R4 forced despite miss
    '{1'b0,1'b1,1'b0,13'h0000,8'h00,4'd6, 1'b1,1'b1,8'hFF}, // R6 forced despite miss
    '{1'b0,1'b0,1'b0,13'h0009,8'h77,4'd9, 1'b1,1'b0,8'h00}, // R9 write with oen low
    '{1'b0,1'b1,1'b0,13'h0008,8'h00,4'd2, 1'b1,1'b1,8'h22}  // R2 second write landed
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Inputs change at the falling edge; outputs are read at the next falling edge.
  task automatic step(input logic c, input logic s, input logic w, input logic o,
                      input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    clear_n = c; sel_n = s; wen_n = w; oen_n = o; idx = a; din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic count_sweep(output int n);
    n = 0;
    while (busy === 1'b1 && n < 3 * DEPTH) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    @(negedge clk);
    step(1'b0, 1'b1, 1'b1, 1'b1, '0, '0);
    step(1'b0, 1'b1, 1'b1, 1'b1, '0, '0);
    // R7 reset state
    chk("R7", match, 1);
    chk("R7", busy, 1);
    chk("R7", dout_en, 0);
    clear_n = 1'b1;
    count_sweep(n);
    chk("R10", n, DEPTH);

    for (int i = 0; i < NV; i++) begin
      step(1'b1, VEC[i].s, VEC[i].w, VEC[i].o, VEC[i].a, VEC[i].d);
      chk($sformatf("R%0d match v%0d", VEC[i].rq, i), match, VEC[i].em);
      chk($sformatf("R%0d dout_en v%0d", VEC[i].rq, i), dout_en, VEC[i].een);
      chk($sformatf("R%0d dout v%0d", VEC[i].rq, i), dout, VEC[i].ed);
    end

    // R9 read back the write made with oen low
    step(1'b1, 1'b0, 1'b1, 1'b0, 13'h0009, 8'h00);
    chk("R9", dout, 8'h77);

    // R7 clear mid-operation, then R11 writes during the sweep
    step(1'b0, 1'b0, 1'b1, 1'b1, 13'h0009, 8'h00);
    chk("R7", match, 1);
    chk("R7", busy, 1);
    clear_n = 1'b1; sel_n = 1'b0; wen_n = 1'b0; oen_n = 1'b1;
    idx = 13'h0000; din = 8'h5A;
    count_sweep(n);
    chk("R10", n, DEPTH);
    step(1'b1, 1'b0, 1'b1, 1'b0, 13'h0000, 8'h00);
    chk("R11", dout, 8'h00);
    step(1'b1, 1'b0, 1'b1, 1'b0, 13'h1FFF, 8'h00);
    chk("R10", dout, 8'h00);
    step(1'b1, 1'b0, 1'b1, 1'b1, 13'h0009, 8'h77);
    chk("R10", match, 0);

    // R2 write after the sweep lands
    step(1'b1, 1'b0, 1'b0, 1'b1, 13'h0000, 8'h5A);
    step(1'b1, 1'b0, 1'b1, 1'b0, 13'h0000, 8'h00);
    chk("R2", dout, 8'h5A);
    step(1'b1, 1'b0, 1'b1, 1'b1, 13'h0000, 8'h5A);
    chk("R3", match, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule